// File: doc/BRIEF.md
# Configuration EEPROM Sequencer

This block moves configuration words between a register file and a 3-wire serial EEPROM. The CPU starts it by setting either a restore command bit or a save command bit. A restore reads EEPROM words into registers. A save writes register contents into EEPROM words. Each command bit reads back as 1 while its operation runs and clears itself in the cycle the last word finishes. A `busy` output tracks the same interval.

A select input is sampled when a command is accepted and picks the set of words. With select high, only the general-purpose register takes part, in either direction. With select low, a restore fills the configuration register, the base register and all three station-address registers. A save with select low writes back only the configuration and base registers, so the station address in the EEPROM is never overwritten.

Every word travels in one serial frame while chip select is high, and a programmable divider sets the serial clock rate. After each written word the sequencer polls the EEPROM's data-out line for its ready level before it starts the next word. What the configuration words mean is outside this block.

Top module: `cfg_eeprom_seq`

## Requirements
- R1: A request sampled at a rising clock edge while idle makes `busy` and the matching command bit read 1 after that edge. Both fall together at the edge where the last word of the operation completes.
- R2: With `sel_gp` = 0, a restore reads EEPROM words 0, 1, 2, 3, 4, in that order, into register indices 0 (configuration), 1 (base) and 2..4 (station address). Register index 5 is not written.
- R3: With `sel_gp` = 0, a save writes register 0 to word 0 and register 1 to word 1, in that order. Words 2, 3, 4 and 8 keep their contents.
- R4: With `sel_gp` = 1, either command transfers only register index 5 (general purpose), which maps to EEPROM word 8. No other register or word changes.
- R5: A frame holds `ee_cs` high and sends these bits on `ee_di`, most significant first: a start bit 1, an opcode (10 = read, 01 = write), a 6-bit word address, then 16 data bits. For a read, `ee_di` is 0 during the data slots. `ee_di` changes only while `ee_sk` is low, and the EEPROM samples it on the rising edge of `ee_sk`.
- R6: During the 16 data slots of a read, the word is taken from `ee_do` most significant bit first. Each bit is sampled at the end of the high phase of its slot.
- R7: After a write frame, `ee_cs` stays low for one full serial slot and then rises again. The sequencer samples `ee_do` at the end of each later slot and starts no new frame until it has seen `ee_do` = 1.
- R8: Each high phase and each low phase of `ee_sk` lasts `clk_div`+1 system clocks (`clk_div` >= 1). While `busy` is 0, `ee_sk` and `ee_cs` are low.
- R9: If a restore request and a save request arrive in the same cycle, the restore runs and the save request is dropped.
- R10: Requests that arrive while `busy` is 1 are ignored. They change neither command bit, nor the select that is in use, nor any EEPROM or register contents.
- R11: `ee_cs` is low whenever no frame and no ready poll is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | 8 | Serial clock half-period, minus one, in system clocks |
| reload_req | input | 1 | Pulse that sets the restore command bit |
| store_req | input | 1 | Pulse that sets the save command bit |
| sel_gp | input | 1 | 1 selects the general-purpose register only; 0 selects the configuration set |
| reload_bit | output | 1 | Restore command bit; clears itself when the operation ends |
| store_bit | output | 1 | Save command bit; clears itself when the operation ends |
| busy | output | 1 | An operation is in progress |
| rf_addr | output | 3 | Register-file index of the current word |
| rf_we | output | 1 | Register-file write strobe (restore only) |
| rf_wdata | output | 16 | Word read from the EEPROM |
| rf_rdata | input | 16 | Combinational read data for `rf_addr` |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready level from the EEPROM |

## Verification
A sequencer whose word index or latched select is wrong shows it within one frame. The address field of the next frame carries the wrong word number, so an EEPROM model that logs every completed frame catches it before any data moves. A bit counter that is off by one produces a frame whose length is not 25 slots when chip select drops, and the same frame leaves a shifted value in the target register or EEPROM word. A poll state that exits early shows up at the next frame's start bit, which arrives while the model still reports a write in progress. A command latch that fails to clear leaves `busy` or a command bit high after the final frame.

// File: rtl/cfg_ee_pkg.sv
package cfg_ee_pkg;
  localparam int EE_AW     = 6;
  localparam int EE_DW     = 16;
  localparam int RF_AW     = 3;
  localparam int OP_W      = 2;
  localparam int CMD_LEN   = 1 + OP_W + EE_AW;
  localparam int FRAME_LEN = CMD_LEN + EE_DW;

  localparam logic [RF_AW-1:0] REG_CFG  = 3'd0;
  localparam logic [RF_AW-1:0] REG_STA2 = 3'd4;
  localparam logic [RF_AW-1:0] REG_GP   = 3'd5;
  localparam logic [EE_AW-1:0] GP_WORD  = 6'd8;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_RELOAD = 2'b01,
    CMD_STORE  = 2'b10
  } cmd_e;

  // Number of words a command moves, from select and direction
  function automatic logic [RF_AW-1:0] plan_len(input logic gp_sel, input logic is_store);
    if (gp_sel)        return 3'd1;
    else if (is_store) return 3'd2;
    else               return 3'd5;
  endfunction

  // Register index of the k-th word of a command
  function automatic logic [RF_AW-1:0] plan_reg(input logic gp_sel, input logic [RF_AW-1:0] k);
    return gp_sel ? REG_GP : k;
  endfunction

  // EEPROM word address that backs a register index
  function automatic logic [EE_AW-1:0] word_of(input logic [RF_AW-1:0] idx);
    if (idx == REG_GP) return GP_WORD;
    return {{(EE_AW-RF_AW){1'b0}}, idx};
  endfunction

  // Serial frame: start bit, opcode, address, data (zeros for a read)
  function automatic logic [FRAME_LEN-1:0] make_frame(input logic is_store,
                                                       input logic [EE_AW-1:0] addr,
                                                       input logic [EE_DW-1:0] data);
    return {1'b1, (is_store ? OP_WRITE : OP_READ), addr, (is_store ? data : {EE_DW{1'b0}})};
  endfunction
endpackage

// File: rtl/cfg_ee_clkgen.sv
module cfg_ee_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sk,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             sk_q;
  logic             tick;

  assign tick = en && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sk_q  <= ~sk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sk      = sk_q;
  assign rise_ev = tick && !sk_q;
  assign fall_ev = tick && sk_q;

  // R8
  half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (cnt_q != '0)) |-> $stable(sk_q));
endmodule

// File: rtl/cfg_ee_shifter.sv
module cfg_ee_shifter #(
  parameter int FLEN = cfg_ee_pkg::FRAME_LEN,
  parameter int CLEN = cfg_ee_pkg::CMD_LEN,
  parameter int DW   = cfg_ee_pkg::EE_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            is_store,
  input  logic [FLEN-1:0] frame,
  input  logic            rise_ev,
  input  logic            fall_ev,
  input  logic            ee_do,
  output logic            active,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic            ee_cs,
  output logic            ee_di
);
  localparam int BW = $clog2(FLEN + 1);

  typedef enum logic [2:0] {SH_IDLE, SH_SHIFT, SH_GAP_LO, SH_GAP_HI, SH_POLL, SH_DONE} sh_e;

  sh_e             st_q;
  logic [FLEN-1:0] sreg_q;
  logic [BW-1:0]   bidx_q;
  logic            wr_q;
  logic            cs_q;
  logic [DW-1:0]   rd_q;
  logic            last_bit;
  logic            data_slot;
  logic            ready_seen;

  assign last_bit   = (bidx_q == BW'(FLEN - 1));
  assign data_slot  = (bidx_q >= BW'(CLEN));
  assign ready_seen = (st_q == SH_POLL) && fall_ev && ee_do;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sreg_q <= '0;
      bidx_q <= '0;
      wr_q   <= 1'b0;
      cs_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (st_q)
        SH_IDLE: if (go) begin
          sreg_q <= frame;
          bidx_q <= '0;
          wr_q   <= is_store;
          cs_q   <= 1'b1;
          st_q   <= SH_SHIFT;
        end
        SH_SHIFT: if (fall_ev) begin
          if (!wr_q && data_slot) rd_q <= {rd_q[DW-2:0], ee_do};
          sreg_q <= {sreg_q[FLEN-2:0], 1'b0};
          if (last_bit) begin
            cs_q <= 1'b0;
            st_q <= wr_q ? SH_GAP_LO : SH_DONE;
          end else begin
            bidx_q <= bidx_q + 1'b1;
          end
        end
        SH_GAP_LO: if (rise_ev) st_q <= SH_GAP_HI;
        SH_GAP_HI: if (fall_ev) begin
          cs_q <= 1'b1;
          st_q <= SH_POLL;
        end
        SH_POLL: if (ready_seen) begin
          cs_q <= 1'b0;
          st_q <= SH_DONE;
        end
        SH_DONE: st_q <= SH_IDLE;
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign active = (st_q == SH_SHIFT) || (st_q == SH_GAP_LO) ||
                  (st_q == SH_GAP_HI) || (st_q == SH_POLL);
  assign done   = (st_q == SH_DONE);
  assign rdata  = rd_q;
  assign ee_cs  = cs_q;
  assign ee_di  = sreg_q[FLEN-1];

  // R11
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ee_cs);

  // R7
  poll_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SH_POLL) && fall_ev && !ee_do) |=> (ee_cs && !done));
endmodule

// File: rtl/cfg_ee_ctrl.sv
module cfg_ee_ctrl
  import cfg_ee_pkg::*;
#(
  parameter int FLEN = cfg_ee_pkg::FRAME_LEN,
  parameter int DW   = cfg_ee_pkg::EE_DW,
  parameter int AW   = cfg_ee_pkg::RF_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload_req,
  input  logic            store_req,
  input  logic            sel_gp,
  input  logic            x_done,
  input  logic [DW-1:0]   x_rdata,
  input  logic [DW-1:0]   rf_rdata,
  output logic            reload_bit,
  output logic            store_bit,
  output logic            busy,
  output logic            go,
  output logic            is_store,
  output logic [FLEN-1:0] frame,
  output logic [AW-1:0]   rf_addr,
  output logic            rf_we,
  output logic [DW-1:0]   rf_wdata
);
  typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_WAIT, C_WB} ctl_e;

  ctl_e          st_q;
  cmd_e          cmd_q;
  logic          sel_q;
  logic [AW-1:0] k_q;
  logic [AW-1:0] item;
  logic          last_item;
  logic          adv_ev;

  assign is_store  = (cmd_q == CMD_STORE);
  assign item      = plan_reg(sel_q, k_q);
  assign last_item = ((k_q + 1'b1) == plan_len(sel_q, is_store));
  assign adv_ev    = ((st_q == C_WAIT) && x_done && is_store) || (st_q == C_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      cmd_q <= CMD_NONE;
      sel_q <= 1'b0;
      k_q   <= '0;
    end else if (adv_ev) begin
      if (last_item) begin
        st_q  <= C_IDLE;
        cmd_q <= CMD_NONE;
      end else begin
        k_q  <= k_q + 1'b1;
        st_q <= C_LAUNCH;
      end
    end else begin
      case (st_q)
        C_IDLE: begin
          if (reload_req) begin
            cmd_q <= CMD_RELOAD;
            sel_q <= sel_gp;
            k_q   <= '0;
            st_q  <= C_LAUNCH;
          end else if (store_req) begin
            cmd_q <= CMD_STORE;
            sel_q <= sel_gp;
            k_q   <= '0;
            st_q  <= C_LAUNCH;
          end
        end
        C_LAUNCH: st_q <= C_WAIT;
        C_WAIT:   if (x_done) st_q <= C_WB;
        default:  st_q <= C_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != C_IDLE);
  assign reload_bit = (cmd_q == CMD_RELOAD);
  assign store_bit  = (cmd_q == CMD_STORE);
  assign go         = (st_q == C_LAUNCH);
  assign frame      = make_frame(is_store, word_of(item), rf_rdata);
  assign rf_addr    = item;
  assign rf_we      = (st_q == C_WB);
  assign rf_wdata   = x_rdata;

  // R1
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == (reload_bit || store_bit)) && $onehot0({reload_bit, store_bit}));

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(sel_q)));

  // R2
  wb_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> reload_bit);

  // R4
  wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (sel_q ? (rf_addr == REG_GP) : (rf_addr <= REG_STA2)));
endmodule

// File: rtl/cfg_eeprom_seq.sv
module cfg_eeprom_seq
  import cfg_ee_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               reload_req,
  input  logic               store_req,
  input  logic               sel_gp,
  output logic               reload_bit,
  output logic               store_bit,
  output logic               busy,
  output logic [RF_AW-1:0]   rf_addr,
  output logic               rf_we,
  output logic [EE_DW-1:0]   rf_wdata,
  input  logic [EE_DW-1:0]   rf_rdata,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  input  logic               ee_do
);
  logic                 x_go;
  logic                 x_store;
  logic [FRAME_LEN-1:0] x_frame;
  logic                 x_active;
  logic                 x_done;
  logic [EE_DW-1:0]     x_rdata;
  logic                 sk_rise;
  logic                 sk_fall;

  cfg_ee_ctrl #(.FLEN(FRAME_LEN), .DW(EE_DW), .AW(RF_AW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_req (reload_req),
    .store_req  (store_req),
    .sel_gp     (sel_gp),
    .x_done     (x_done),
    .x_rdata    (x_rdata),
    .rf_rdata   (rf_rdata),
    .reload_bit (reload_bit),
    .store_bit  (store_bit),
    .busy       (busy),
    .go         (x_go),
    .is_store   (x_store),
    .frame      (x_frame),
    .rf_addr    (rf_addr),
    .rf_we      (rf_we),
    .rf_wdata   (rf_wdata)
  );

  cfg_ee_shifter #(.FLEN(FRAME_LEN), .CLEN(CMD_LEN), .DW(EE_DW)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (x_go),
    .is_store (x_store),
    .frame    (x_frame),
    .rise_ev  (sk_rise),
    .fall_ev  (sk_fall),
    .ee_do    (ee_do),
    .active   (x_active),
    .done     (x_done),
    .rdata    (x_rdata),
    .ee_cs    (ee_cs),
    .ee_di    (ee_di)
  );

  cfg_ee_clkgen #(.DIV_W(DIV_W)) clk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (x_active),
    .div     (clk_div),
    .sk      (ee_sk),
    .rise_ev (sk_rise),
    .fall_ev (sk_fall)
  );

  // R5
  di_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  // R8
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_sk && !ee_cs));
endmodule

// File: tb/cfg_eeprom_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_eeprom_seq_tb_top;
  localparam int BUSY_CLKS = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        reload_req = 1'b0, store_req = 1'b0, sel_gp = 1'b0;
  logic        reload_bit, store_bit, busy;
  logic [2:0]  rf_addr;
  logic        rf_we;
  logic [15:0] rf_wdata, rf_rdata;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfg_eeprom_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .reload_req(reload_req), .store_req(store_req), .sel_gp(sel_gp),
    .reload_bit(reload_bit), .store_bit(store_bit), .busy(busy),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'h3C00 ^ 16'(a * 16'h0123);
  endfunction

  // ---------------- register file model ----------------
  logic [15:0] rfm [0:7];
  logic        tb_rf_we = 1'b0;
  logic [2:0]  tb_rf_idx = '0;
  logic [15:0] tb_rf_val = '0;

  always @(posedge clk) begin
    if (tb_rf_we) rfm[tb_rf_idx] <= tb_rf_val;
    else if (rf_we) rfm[rf_addr] <= rf_wdata;
  end
  assign rf_rdata = rfm[rf_addr];

  // ---------------- serial EEPROM model ----------------
  logic [15:0] mem [0:63];
  logic        sk_p, cs_p, started, mdl_do, log_clr = 1'b0;
  int          nb, busy_cnt, early_viol, frame_err, log_n;
  logic [8:0]  cmd;
  logic [15:0] wdat;
  logic [1:0]  log_op [0:15];
  logic [5:0]  log_addr [0:15];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      sk_p <= 0; cs_p <= 0; started <= 0; nb <= 0; cmd <= '0; wdat <= '0;
      mdl_do <= 0; busy_cnt <= 0; early_viol <= 0; frame_err <= 0; log_n <= 0;
    end else begin
      sk_p <= ee_sk;
      cs_p <= ee_cs;
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (log_clr) log_n <= 0;
      if (ee_sk && !sk_p && ee_cs) begin
        if (!started) begin
          if (ee_di) begin
            started <= 1; nb <= 1; cmd <= 9'h1;
            if (busy_cnt != 0) early_viol <= early_viol + 1;
          end
        end else if (nb < 9) begin
          cmd <= {cmd[7:0], ee_di}; nb <= nb + 1;
        end else if (nb < 25) begin
          if (cmd[7:6] == 2'b10) mdl_do <= mem[cmd[5:0]][24-nb];
          else wdat <= {wdat[14:0], ee_di};
          nb <= nb + 1;
        end
      end
      if (!ee_cs && cs_p) begin
        if (started) begin
          if (nb == 25) begin
            if (cmd[7:6] == 2'b01) begin
              mem[cmd[5:0]] <= wdat;
              busy_cnt <= BUSY_CLKS;
            end
            if (log_n < 16 && !log_clr) begin
              log_op[log_n] <= cmd[7:6];
              log_addr[log_n] <= cmd[5:0];
              log_n <= log_n + 1;
            end
          end else frame_err <= frame_err + 1;
        end
        started <= 0; nb <= 0;
      end
    end
  end

  assign ee_do = (started && cmd[7:6] == 2'b10 && nb >= 10) ? mdl_do
               : (ee_cs && !started && busy_cnt == 0);

  // ---------------- bench helpers ----------------
  logic [15:0] exp_mem [0:63];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_rf(input int idx, input logic [15:0] v);
    @(negedge clk);
    tb_rf_we = 1; tb_rf_idx = 3'(idx); tb_rf_val = v;
    @(negedge clk);
    tb_rf_we = 0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1;
    @(negedge clk); log_clr = 0;
  endtask

  task automatic pulse(input logic rl, input logic st, input logic g);
    @(negedge clk);
    reload_req = rl; store_req = st; sel_gp = g;
    @(negedge clk);
    reload_req = 0; store_req = 0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_log(input string req, input int idx,
                           input logic [1:0] op, input logic [5:0] a);
    check(req, $sformatf("log[%0d] opcode", idx), {30'd0, log_op[idx]}, {30'd0, op});
    check(req, $sformatf("log[%0d] address", idx), {26'd0, log_addr[idx]}, {26'd0, a});
  endtask

  task automatic check_mem_all(input string req);
    for (int i = 0; i < 64; i++)
      if (mem[i] !== exp_mem[i]) check(req, $sformatf("word %0d", i), {16'd0, mem[i]}, {16'd0, exp_mem[i]});
    check(req, "EEPROM image matches", 1, 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1", "busy after reset", {31'd0, busy}, 0);
    check("R1", "command bits after reset", {30'd0, reload_bit, store_bit}, 0);
    check("R8", "sk/cs idle after reset", {30'd0, ee_sk, ee_cs}, 0);
  endtask

  task automatic t_reload_gp();
    int cyc, hi;
    clk_div = 8'd2;
    for (int i = 0; i < 6; i++) set_rf(i, 16'hEE00 + 16'(i));
    clear_log();
    pulse(1, 0, 1);
    check("R1", "busy after restore request", {31'd0, busy}, 1);
    check("R1", "restore bit set", {30'd0, reload_bit, store_bit}, 2);
    while (!ee_sk) @(negedge clk);
    hi = 0;
    while (ee_sk) begin @(negedge clk); hi++; end
    check("R8", "sk high phase with div 2", hi, 3);
    hi = 0;
    while (!ee_sk) begin @(negedge clk); hi++; end
    check("R8", "sk low phase with div 2", hi, 3);
    wait_idle(cyc);
    check("R1", "restore bit cleared at end", {31'd0, reload_bit}, 0);
    check("R4", "GP register restored from word 8", {16'd0, rfm[5]}, {16'd0, exp_mem[8]});
    check("R4", "config register untouched", {16'd0, rfm[0]}, 32'hEE00);
    check("R4", "one frame only", log_n, 1);
    check_log("R4", 0, 2'b10, 6'd8);
    check("R6", "GP value bit order", {16'd0, rfm[5]}, {16'd0, pat(8)});
  endtask

  task automatic t_reload_cfg();
    int cyc;
    clk_div = 8'd1;
    for (int i = 0; i < 6; i++) set_rf(i, 16'hD100 + 16'(i));
    clear_log();
    pulse(1, 0, 0);
    wait_idle(cyc);
    check("R1", "busy cleared", {31'd0, busy}, 0);
    for (int i = 0; i < 5; i++)
      check("R2", $sformatf("register %0d restored", i), {16'd0, rfm[i]}, {16'd0, exp_mem[i]});
    check("R2", "register 5 untouched", {16'd0, rfm[5]}, 32'hD105);
    check("R5", "five frames", log_n, 5);
    for (int i = 0; i < 5; i++) check_log("R5", i, 2'b10, 6'(i));
    check("R5", "frame length errors", frame_err, 0);
  endtask

  task automatic t_store_cfg();
    int cyc;
    for (int i = 0; i < 6; i++) set_rf(i, 16'hC0DE ^ 16'(i * 16'h1111));
    clear_log();
    pulse(0, 1, 0);
    check("R1", "save bit set", {30'd0, reload_bit, store_bit}, 1);
    wait_idle(cyc);
    exp_mem[0] = rfm[0];
    exp_mem[1] = rfm[1];
    check("R1", "save bit cleared", {31'd0, store_bit}, 0);
    check("R3", "word 0", {16'd0, mem[0]}, {16'd0, 16'hC0DE});
    check("R3", "word 1", {16'd0, mem[1]}, {16'd0, 16'hC0DE ^ 16'h1111});
    check_mem_all("R3");
    check("R3", "two frames", log_n, 2);
    check_log("R3", 0, 2'b01, 6'd0);
    check_log("R3", 1, 2'b01, 6'd1);
    check("R7", "no frame started while EEPROM busy", early_viol, 0);
    check("R7", "save lasted past both write cycles", {31'd0, cyc > 2 * BUSY_CLKS}, 1);
  endtask

  task automatic t_store_gp();
    int cyc;
    set_rf(5, 16'h6E55);
    clear_log();
    pulse(0, 1, 1);
    wait_idle(cyc);
    exp_mem[8] = 16'h6E55;
    check_mem_all("R4");
    check("R4", "one write frame", log_n, 1);
    check_log("R4", 0, 2'b01, 6'd8);
    check("R7", "no early start", early_viol, 0);
  endtask

  task automatic t_both();
    int cyc;
    set_rf(5, 16'h0BAD);
    clear_log();
    pulse(1, 1, 1);
    check("R9", "restore wins", {30'd0, reload_bit, store_bit}, 2);
    wait_idle(cyc);
    check("R9", "GP restored", {16'd0, rfm[5]}, {16'd0, exp_mem[8]});
    check_mem_all("R9");
    check("R9", "only a read frame", log_n, 1);
    check_log("R9", 0, 2'b10, 6'd8);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    set_rf(5, 16'h7777);
    clear_log();
    pulse(1, 0, 0);
    repeat (20) @(negedge clk);
    pulse(0, 1, 1);
    check("R10", "save bit stays clear while busy", {30'd0, reload_bit, store_bit}, 2);
    pulse(1, 0, 1);
    check("R10", "restore still running", {30'd0, reload_bit, store_bit}, 2);
    wait_idle(cyc);
    check("R10", "no leftover command", {29'd0, busy, reload_bit, store_bit}, 0);
    check("R10", "five read frames", log_n, 5);
    for (int i = 0; i < 5; i++) check_log("R10", i, 2'b10, 6'(i));
    check("R10", "GP register untouched", {16'd0, rfm[5]}, 32'h7777);
    check_mem_all("R10");
    repeat (10) @(negedge clk);
    check("R8", "lines idle after finish", {30'd0, ee_sk, ee_cs}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reload_gp();
    t_reload_cfg();
    t_store_cfg();
    t_store_gp();
    t_both();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule